// File: doc/BRIEF.md
# Vector Signed-to-Unsigned Saturating Narrow Unit

This block takes a packed vector of two's-complement signed integers and turns each element into an unsigned value of half its width. Values below zero become zero, and values too large for the half-width field become all ones. A 3-bit size code, made of one high field bit placed above two low field bits, picks the source element width at run time: 16, 32 or 64 bits. Each narrowed value goes into the even-numbered half-width lane of its element's slot, and the odd-numbered lane beside it is cleared.

The unit is a single registered stage with no handshake. When the input valid is high, the result appears on the following clock edge together with an output valid, or with an illegal-size flag if the code is not one of the three legal codes. The vector length is a parameter and must be a multiple of 64. Lane 0 sits in the least significant bits of both the input and the output vectors.

Top module: `vsn_unit`

## Requirements
- R1: The size code is {size_hi, size_lo[1:0]}. Code 3'b001 selects 16-bit source elements, 3'b010 selects 32-bit and 3'b100 selects 64-bit. Every other code is illegal.
- R2: An input with in_valid high and an illegal code gives out_illegal = 1 and out_valid = 0 on the next cycle. out_valid and out_illegal are never high together.
- R3: Each source element is read as two's complement. Any negative element gives a result of zero.
- R4: A non-negative element greater than 2^H-1 gives a result of all ones, where H is half the source width.
- R5: An element in the range 0 to 2^H-1 passes through unchanged.
- R6: The result for source element e of width W occupies out_vec[e*W +: W/2], and out_vec[e*W+W/2 +: W/2] is zero.
- R7: All VLEN/W elements of the vector are processed, including the top one.
- R8: An input with in_valid high and a legal code gives out_valid = 1 and out_illegal = 0 one cycle later. A cycle with in_valid low gives out_valid = 0 and out_illegal = 0 on the next cycle.
- R9: While out_illegal is high, out_vec is all zeros.
- R10: out_vec keeps its value after any cycle in which in_valid is low, whatever the data and code inputs carry.
- R11: After reset, out_valid, out_illegal and out_vec are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | The input vector and size code are present this cycle |
| size_hi | input | 1 | High bit of the size code |
| size_lo | input | 2 | Low two bits of the size code |
| in_vec | input | VLEN | Packed signed source elements, element 0 in the low bits |
| out_valid | output | 1 | out_vec holds a narrowed result |
| out_illegal | output | 1 | The previous input carried an illegal size code |
| out_vec | output | VLEN | Narrowed results in even lanes, zeros in odd lanes |

## Verification
Both clamp directions and the in-range pass-through can occur in one vector on the same cycle, one per element. The bench provokes this with directed vectors that place the most negative value, -1, zero, 2^H-1, 2^H and the most positive value in neighbouring elements, including the top element. It also mixes random elements biased towards these boundaries, and compares every lane against a bench-side model. Illegal codes are sent in the cycle right after legal ones, and the reverse, so the bench can confirm that the flag, the valid and the zeroed vector change over cleanly from one cycle to the next.

// File: rtl/vsn_pkg.sv
package vsn_pkg;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SZ_ELEM16 = 3'b001,
    SZ_ELEM32 = 3'b010,
    SZ_ELEM64 = 3'b100
  } size_code_e;

  // one-hot width selector: bit 0 = 16, bit 1 = 32, bit 2 = 64
  typedef logic [2:0] width_sel_t;

endpackage

// File: rtl/vsn_rst_sync.sv
module vsn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/vsn_size_decode.sv
module vsn_size_decode
  import vsn_pkg::*;
(
  input  logic                    size_hi,
  input  logic [1:0]              size_lo,
  output width_sel_t              wsel_o,
  output logic                    legal_o
);

  logic [CODE_W-1:0] code;

  always_comb begin
    code   = {size_hi, size_lo};
    wsel_o = '0;
    unique case (code)
      SZ_ELEM16: wsel_o = 3'b001;
      SZ_ELEM32: wsel_o = 3'b010;
      SZ_ELEM64: wsel_o = 3'b100;
      default:   wsel_o = '0;
    endcase
    legal_o = |wsel_o;
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(wsel_o)); // R1
  end

endmodule

// File: rtl/vsn_lane_sat.sv
module vsn_lane_sat #(
  parameter int unsigned SRC_W = 16,
  localparam int unsigned HALF_W = SRC_W / 2
) (
  input  logic [SRC_W-1:0] src_i,
  output logic [SRC_W-1:0] slot_o
);

  logic              is_neg;
  logic              too_big;
  logic [HALF_W-1:0] narrow;

  always_comb begin
    is_neg  = src_i[SRC_W-1];
    too_big = |src_i[SRC_W-2:HALF_W];
    if (is_neg) begin
      narrow = '0;
    end else if (too_big) begin
      narrow = '1;
    end else begin
      narrow = src_i[HALF_W-1:0];
    end
    slot_o = {{HALF_W{1'b0}}, narrow};
  end

endmodule

// File: rtl/vsn_width_path.sv
module vsn_width_path #(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned SRC_W = 16,
  localparam int unsigned N_ELEM = VLEN / SRC_W
) (
  input  logic [VLEN-1:0] vec_i,
  output logic [VLEN-1:0] vec_o
);

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    vsn_lane_sat #(
      .SRC_W (SRC_W)
    ) i_sat (
      .src_i  (vec_i[e*SRC_W +: SRC_W]),
      .slot_o (vec_o[e*SRC_W +: SRC_W])
    );
  end

endmodule

// File: rtl/vsn_unit.sv
module vsn_unit
  import vsn_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            size_hi,
  input  logic [1:0]      size_lo,
  input  logic [VLEN-1:0] in_vec,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [VLEN-1:0] out_vec
);

  localparam int unsigned N_WIDTHS = 3;
  localparam int unsigned BASE_W   = 16;

  logic                  rst_q_n;
  width_sel_t            wsel;
  logic                  legal;
  logic [VLEN-1:0]       path_vec [N_WIDTHS];
  logic [VLEN-1:0]       odd_mask [N_WIDTHS];

  logic                  valid_d, valid_q;
  logic                  ill_d, ill_q;
  logic                  vec_en;
  logic [VLEN-1:0]       vec_d, vec_q;

  vsn_rst_sync #(
    .STAGES (2)
  ) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  vsn_size_decode i_decode (
    .size_hi (size_hi),
    .size_lo (size_lo),
    .wsel_o  (wsel),
    .legal_o (legal)
  );

  for (genvar w = 0; w < N_WIDTHS; w++) begin : g_width
    localparam int unsigned SW = BASE_W << w;
    localparam int unsigned HW = SW / 2;

    vsn_width_path #(
      .VLEN  (VLEN),
      .SRC_W (SW)
    ) i_path (
      .vec_i (in_vec),
      .vec_o (path_vec[w])
    );

    // odd-lane mask used by the checks below
    for (genvar e = 0; e < VLEN / SW; e++) begin : g_mask
      assign odd_mask[w][e*SW +: SW] = {{HW{1'b1}}, {HW{1'b0}}};
    end
  end

  // next state
  always_comb begin
    vec_d = '0;
    for (int w = 0; w < N_WIDTHS; w++) begin
      if (wsel[w]) begin
        vec_d = path_vec[w];
      end
    end
    valid_d = in_valid & legal;
    ill_d   = in_valid & ~legal;
    vec_en  = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ill_q   <= ill_d;
      if (vec_en) begin
        vec_q <= vec_d;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = ill_q;
  assign out_vec     = vec_q;

  // checks
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(out_valid && out_illegal)); // R2

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !({size_hi, size_lo} inside {3'b001, 3'b010, 3'b100}))
      |=> (out_illegal && !out_valid)); // R2

  AST_GOOD_CODE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && ({size_hi, size_lo} inside {3'b001, 3'b010, 3'b100}))
      |=> (out_valid && !out_illegal)); // R8

  AST_ILL_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_illegal |-> (out_vec == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_vec) && !out_valid && !out_illegal)); // R10

  AST_ODD16_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && {size_hi, size_lo} == 3'b001) |=> ((out_vec & odd_mask[0]) == '0)); // R6

  AST_ODD32_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && {size_hi, size_lo} == 3'b010) |=> ((out_vec & odd_mask[1]) == '0)); // R6

  AST_ODD64_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && {size_hi, size_lo} == 3'b100) |=> ((out_vec & odd_mask[2]) == '0)); // R6

endmodule

// File: tb/test_vsn_unit.sv
module test_vsn_unit;

  localparam int unsigned VLEN = 128;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            size_hi;
  logic [1:0]      size_lo;
  logic [VLEN-1:0] in_vec;
  logic            out_valid;
  logic            out_illegal;
  logic [VLEN-1:0] out_vec;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 0;

  logic            exp_valid;
  logic            exp_ill;
  logic [VLEN-1:0] exp_vec;
  string           cur_tag;

  vsn_unit #(.VLEN(VLEN)) i_vsn_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .size_hi     (size_hi),
    .size_lo     (size_lo),
    .in_vec      (in_vec),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_vec     (out_vec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  function automatic int width_of(input logic [2:0] code);
    case (code)
      3'b001:  return 16;
      3'b010:  return 32;
      3'b100:  return 64;
      default: return 0;
    endcase
  endfunction

  // bench-side model of one narrow operation
  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] v, input logic [2:0] code);
    logic [VLEN-1:0] r;
    int w, h;
    longint x, lim;
    r = '0;
    w = width_of(code);
    if (w == 0) return r;
    h = w / 2;
    lim = (longint'(1) << h) - 1;
    for (int e = 0; e < VLEN / w; e++) begin
      x = 0;
      for (int j = 0; j < 64; j++) begin
        x[j] = (j < w) ? v[e*w + j] : v[e*w + w - 1];
      end
      if (x < 0) x = 0;
      else if (x > lim) x = lim;
      for (int j = 0; j < h; j++) r[e*w + j] = x[j];
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] put_elem(input logic [VLEN-1:0] v, input int w,
                                               input int e, input longint val);
    logic [VLEN-1:0] r;
    r = v;
    for (int j = 0; j < w; j++) r[e*w + j] = val[j];
    return r;
  endfunction

  task automatic check_out(input string tag);
    n_checks++;
    if (out_valid !== exp_valid) begin
      n_fails++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, exp_valid);
    end
    n_checks++;
    if (out_illegal !== exp_ill) begin
      n_fails++;
      $display("FAIL %s out_illegal actual=%0b expected=%0b", tag, out_illegal, exp_ill);
    end
    n_checks++;
    if (out_vec !== exp_vec) begin
      n_fails++;
      $display("FAIL %s out_vec actual=%h expected=%h", tag, out_vec, exp_vec);
    end
  endtask

  // drive one cycle at negedge, then check the registered result at the next negedge
  task automatic step(input logic v, input logic [2:0] code, input logic [VLEN-1:0] data,
                      input string tag);
    in_valid = v;
    {size_hi, size_lo} = code;
    in_vec = data;
    if (v) begin
      if (width_of(code) != 0) begin
        exp_valid = 1'b1; exp_ill = 1'b0; exp_vec = model(data, code);
      end else begin
        exp_valid = 1'b0; exp_ill = 1'b1; exp_vec = '0;
      end
    end else begin
      exp_valid = 1'b0; exp_ill = 1'b0;
    end
    @(negedge clk);
    check_out(tag);
  endtask

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] r;
    logic [15:0] pick;
    for (int c = 0; c < VLEN / 16; c++) begin
      case ($urandom % 6)
        0: pick = 16'h0000;
        1: pick = 16'hFFFF;
        2: pick = 16'h7FFF;
        3: pick = 16'h8000;
        4: pick = 16'h00FF + 16'($urandom % 3);
        default: pick = 16'($urandom);
      endcase
      r[c*16 +: 16] = pick;
    end
    return r;
  endfunction

  task automatic directed_width(input logic [2:0] code);
    logic [VLEN-1:0] v;
    int w, h, n;
    longint lim, minv, maxv;
    w = width_of(code);
    h = w / 2;
    n = VLEN / w;
    lim = (longint'(1) << h) - 1;
    minv = (w == 64) ? 64'sh8000_0000_0000_0000 : -(longint'(1) << (w - 1));
    maxv = (w == 64) ? 64'sh7FFF_FFFF_FFFF_FFFF : (longint'(1) << (w - 1)) - 1;
    // R3: negative values clamp to zero
    v = '0;
    for (int e = 0; e < n; e++) v = put_elem(v, w, e, (e % 2 == 0) ? minv : -1);
    step(1'b1, code, v, "R3");
    // R4: above the half-width range clamps to all ones
    for (int e = 0; e < n; e++) v = put_elem(v, w, e, (e % 2 == 0) ? lim + 1 : maxv);
    step(1'b1, code, v, "R4");
    // R5: in-range values pass through
    for (int e = 0; e < n; e++) v = put_elem(v, w, e, (e % 2 == 0) ? lim : 0);
    step(1'b1, code, v, "R5");
    // R6/R7: mixed clamps, top element distinct
    for (int e = 0; e < n; e++) v = put_elem(v, w, e, longint'(e) * 3 - 2);
    v = put_elem(v, w, n - 1, maxv);
    step(1'b1, code, v, "R6");
    v = put_elem(v, w, n - 1, lim - 1);
    step(1'b1, code, v, "R7");
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] code;
    logic [VLEN-1:0] keep;
    void'($urandom(32'd20261));
    rst_n = 1'b0;
    in_valid = 1'b0;
    {size_hi, size_lo} = 3'b000;
    in_vec = '0;
    exp_valid = 1'b0; exp_ill = 1'b0; exp_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R11");

    // R1: each legal code selects its width
    step(1'b1, 3'b001, {VLEN/16{16'h0123}}, "R1");
    step(1'b1, 3'b010, {VLEN/32{32'h0001_2345}}, "R1");
    step(1'b1, 3'b100, {VLEN/64{64'h0000_0000_89AB_CDEF}}, "R1");

    directed_width(3'b001);
    directed_width(3'b010);
    directed_width(3'b100);

    // R2/R9: every illegal code, back to back with legal ones
    for (int c = 0; c < 8; c++) begin
      if (width_of(3'(c)) == 0) begin
        step(1'b1, 3'b001, {VLEN/16{16'h0042}}, "R8");
        step(1'b1, 3'(c), {VLEN/16{16'h0042}}, "R2");
        step(1'b1, 3'(c), rand_vec(), "R9");
      end
    end

    // R10: idle cycles with junk on the inputs
    step(1'b1, 3'b010, rand_vec(), "R8");
    keep = exp_vec;
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 3'($urandom), rand_vec(), "R10");
      n_checks++;
      if (out_vec !== keep) begin
        n_fails++;
        $display("FAIL R10 held out_vec actual=%h expected=%h", out_vec, keep);
      end
    end

    // random mix
    for (int k = 0; k < 3000; k++) begin
      case ($urandom % 10)
        0:       code = 3'($urandom);
        1, 2, 3: code = 3'b001;
        4, 5, 6: code = 3'b010;
        default: code = 3'b100;
      endcase
      step(($urandom % 8) != 0, code, rand_vec(), "R7");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule